// File: doc/BRIEF.md
# CAN Frame Acceptance Filter Bank

This block decides whether a received CAN frame is kept and, if so, which acceptance filter claims it. The receive path hands over a 48-bit key, formed from the frame identifier followed by the first two payload bytes. The block holds a bank of programmable filters. Each filter has a 48-bit match value and a 48-bit care mask. An enable bitmap picks which filters take part in the decision.

A host loads the match values, the masks and the enable bitmap through a simple write port while the receiver is off. Once `rx_enable` is raised, the tables are frozen. Each `frame_valid` strobe then starts a scan that walks the filters in ascending order, one per clock. The scan stops at the first enabled filter that passes. The result is reported with a one-cycle `done` pulse, an `accept` flag and the winning filter number. A frame that no enabled filter passes is reported as rejected.

Top module: `can_accept_filter_bank`

## Requirements
- R1: After reset, `done`, `accept` and `filter_idx` are 0 and every enable bit is cleared, so a frame scanned before any enable write is rejected.
- R2: Filter k passes a key when `((key ^ match[k]) & mask[k]) == 0`. A mask bit of 1 requires equality and a mask bit of 0 is don't care. Writes use `cfg_sel` = 0 for the match value and 1 for the mask, with `cfg_addr` as the filter number and `cfg_wdata` as the 48-bit value.
- R3: Only filters whose enable bit is 1 can accept a frame. A write with `cfg_sel` = 2 loads enable byte `cfg_addr[4:0]` from `cfg_wdata[7:0]`, and bit i of byte b is the enable of filter 8*b+i. A write with `cfg_sel` = 3 has no effect.
- R4: When several enabled filters pass, the lowest-numbered one is reported.
- R5: When no enabled filter passes, `done` pulses with `accept` = 0 and `filter_idx` = 0, exactly NUM_FILTERS cycles after the capture edge.
- R6: A frame captured at clock edge E and accepted by filter k raises `done` for exactly one cycle, after edge E+k+1, with `accept` = 1 and `filter_idx` = k. Both outputs then hold until the next `done`.
- R7: While `rx_enable` is 1, writes to the match, mask and enable tables are ignored.
- R8: `frame_valid` is ignored while `rx_enable` is 0 and while a scan is in progress. An ignored strobe is not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_enable | input | 1 | Receiver on; starts frame handling and freezes the tables |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Table select: 0 match, 1 mask, 2 enable byte, 3 none |
| cfg_addr | input | 8 | Filter number, or enable byte number in bits [4:0] |
| cfg_wdata | input | 48 | Write data; bits [7:0] for enable bytes |
| frame_valid | input | 1 | Strobe: a new frame key is present |
| frame_key | input | 48 | Identifier and first two payload bytes |
| done | output | 1 | One-cycle pulse marking the end of a scan |
| accept | output | 1 | Frame accepted by some enabled filter |
| filter_idx | output | 8 | Number of the winning filter; 0 on rejection |

## Verification
The hardest case to reach from the ports is a strobe that arrives in the middle of a running scan. The bench must show that this strobe neither disturbs the result of the current scan nor starts a second scan afterwards. To reach it, a key is chosen that only a high-numbered filter accepts, which keeps the scan busy for about two hundred cycles. A second strobe, carrying a key that a low filter would accept, is then injected a few cycles in. The bench checks that the first result is unchanged, and then watches through a full scan length to confirm that no extra `done` appears. Lowest-index priority and the enable byte/bit ordering are exercised by catch-all filters placed in different enable bytes. The frozen-table rule is exercised by writes issued with the receiver on, each followed by frames whose outcome would change if the write had landed.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;

  typedef enum logic [1:0] {
    SEL_MATCH  = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_NONE   = 2'd3
  } tbl_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scan_state_e;

endpackage

// File: rtl/filt_rst_sync.sv
module filt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_out_n = chain_q[STAGES-1];

endmodule

// File: rtl/filt_table.sv
module filt_table
  import can_filt_pkg::*;
#(
  parameter int NUM_FILTERS = 256,
  parameter int KEY_W       = 48,
  localparam int IDX_W      = $clog2(NUM_FILTERS),
  localparam int EN_BYTES   = NUM_FILTERS / 8,
  localparam int EB_W       = $clog2(EN_BYTES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lock,
  input  logic                   we,
  input  logic [1:0]             sel,
  input  logic [IDX_W-1:0]       addr,
  input  logic [KEY_W-1:0]       wdata,
  input  logic [IDX_W-1:0]       rd_idx,
  output logic [KEY_W-1:0]       rd_match,
  output logic [KEY_W-1:0]       rd_mask,
  output logic                   rd_en,
  output logic [NUM_FILTERS-1:0] en_bits
);

  logic [KEY_W-1:0]       match_mem [NUM_FILTERS];
  logic [KEY_W-1:0]       mask_mem  [NUM_FILTERS];
  logic [NUM_FILTERS-1:0] en_q;
  logic [NUM_FILTERS-1:0] en_d;
  logic [EN_BYTES-1:0]    byte_we;
  logic                   wr_ok;
  logic                   addr_in_range;
  logic                   match_we;
  logic                   mask_we;

  // Table writes are accepted only while the receiver is off.
  assign wr_ok         = we && !lock;
  assign addr_in_range = ({1'b0, addr} < (IDX_W+1)'(NUM_FILTERS));
  assign match_we      = wr_ok && addr_in_range && (tbl_sel_e'(sel) == SEL_MATCH);
  assign mask_we       = wr_ok && addr_in_range && (tbl_sel_e'(sel) == SEL_MASK);

  always_ff @(posedge clk) begin
    if (match_we) match_mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (mask_we) mask_mem[addr] <= wdata;
  end

  // Enable bitmap: byte b covers filters 8*b .. 8*b+7.
  always_comb begin
    en_d    = en_q;
    byte_we = '0;
    for (int b = 0; b < EN_BYTES; b++) begin
      if (wr_ok && (tbl_sel_e'(sel) == SEL_ENABLE) && (addr[EB_W-1:0] == EB_W'(b))) begin
        byte_we[b]     = 1'b1;
        en_d[b*8 +: 8] = wdata[7:0];
      end
    end
  end

  for (genvar gb = 0; gb < EN_BYTES; gb++) begin : g_en_byte
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           en_q[gb*8 +: 8] <= '0;
      else if (byte_we[gb]) en_q[gb*8 +: 8] <= en_d[gb*8 +: 8];
    end
  end

  assign rd_match = match_mem[rd_idx];
  assign rd_mask  = mask_mem[rd_idx];
  assign rd_en    = en_q[rd_idx];
  assign en_bits  = en_q;

endmodule

// File: rtl/filt_match.sv
module filt_match #(
  parameter int KEY_W = 48
) (
  input  logic [KEY_W-1:0] key,
  input  logic [KEY_W-1:0] match_val,
  input  logic [KEY_W-1:0] care_mask,
  input  logic             enabled,
  output logic             hit
);

  logic [KEY_W-1:0] diff;

  // A differing bit only counts where the mask marks it as cared about.
  assign diff = (key ^ match_val) & care_mask;
  assign hit  = enabled & (diff == '0);

endmodule

// File: rtl/filt_scan.sv
module filt_scan
  import can_filt_pkg::*;
#(
  parameter int NUM_FILTERS = 256,
  parameter int KEY_W       = 48,
  localparam int IDX_W      = $clog2(NUM_FILTERS),
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FILTERS - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KEY_W-1:0] frame_key,
  input  logic             hit,
  output logic [IDX_W-1:0] scan_idx,
  output logic [KEY_W-1:0] key_q,
  output logic             busy,
  output logic             done,
  output logic             accept,
  output logic [IDX_W-1:0] filter_idx
);

  scan_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             acc_q, acc_d;
  logic [IDX_W-1:0] fidx_q, fidx_d;
  logic             key_load;

  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    done_d   = 1'b0;
    acc_d    = acc_q;
    fidx_d   = fidx_q;
    key_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_SCAN;
          idx_d    = '0;
          key_load = 1'b1;
        end
      end
      ST_SCAN: begin
        if (hit) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          acc_d   = 1'b1;
          fidx_d  = idx_q;
        end else if (idx_q == LAST_IDX) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          acc_d   = 1'b0;
          fidx_d  = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
      acc_q   <= 1'b0;
      fidx_q  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
      acc_q   <= acc_d;
      fidx_q  <= fidx_d;
    end
  end

  // Datapath register: loaded only on a new frame, no reset needed.
  always_ff @(posedge clk) begin
    if (key_load) key_q <= frame_key;
  end

  assign scan_idx   = idx_q;
  assign busy       = (state_q == ST_SCAN);
  assign done       = done_q;
  assign accept     = acc_q;
  assign filter_idx = fidx_q;

endmodule

// File: rtl/can_accept_filter_bank.sv
module can_accept_filter_bank
  import can_filt_pkg::*;
#(
  parameter int NUM_FILTERS = 256,
  parameter int KEY_W       = 48,
  localparam int IDX_W      = $clog2(NUM_FILTERS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_enable,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [IDX_W-1:0] cfg_addr,
  input  logic [KEY_W-1:0] cfg_wdata,
  input  logic             frame_valid,
  input  logic [KEY_W-1:0] frame_key,
  output logic             done,
  output logic             accept,
  output logic [IDX_W-1:0] filter_idx
);

  logic                   rst_sync_n;
  logic [IDX_W-1:0]       scan_idx;
  logic [KEY_W-1:0]       key_q;
  logic [KEY_W-1:0]       rd_match;
  logic [KEY_W-1:0]       rd_mask;
  logic                   rd_en;
  logic [NUM_FILTERS-1:0] en_bits;
  logic                   hit;
  logic                   busy;
  logic                   start;

  assign start = frame_valid && rx_enable;

  filt_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk       (clk),
    .rst_in_n  (rst_n),
    .rst_out_n (rst_sync_n)
  );

  filt_table #(.NUM_FILTERS(NUM_FILTERS), .KEY_W(KEY_W)) table_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .lock     (rx_enable),
    .we       (cfg_we),
    .sel      (cfg_sel),
    .addr     (cfg_addr),
    .wdata    (cfg_wdata),
    .rd_idx   (scan_idx),
    .rd_match (rd_match),
    .rd_mask  (rd_mask),
    .rd_en    (rd_en),
    .en_bits  (en_bits)
  );

  filt_match #(.KEY_W(KEY_W)) match_i (
    .key       (key_q),
    .match_val (rd_match),
    .care_mask (rd_mask),
    .enabled   (rd_en),
    .hit       (hit)
  );

  filt_scan #(.NUM_FILTERS(NUM_FILTERS), .KEY_W(KEY_W)) scan_i (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .start      (start),
    .frame_key  (frame_key),
    .hit        (hit),
    .scan_idx   (scan_idx),
    .key_q      (key_q),
    .busy       (busy),
    .done       (done),
    .accept     (accept),
    .filter_idx (filter_idx)
  );

endmodule

// File: rtl/filt_bank_checker.sv
module filt_bank_checker #(
  parameter int NUM_FILTERS = 256,
  localparam int IDX_W      = $clog2(NUM_FILTERS)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   rx_enable,
  input logic                   cfg_we,
  input logic                   busy,
  input logic                   done,
  input logic                   accept,
  input logic [IDX_W-1:0]       filter_idx,
  input logic [NUM_FILTERS-1:0] en_bits
);

  // R6: done lasts a single cycle
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6: a result only follows a scan that was running
  assert_done_after_scan_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));

  // R6: result outputs hold between done pulses
  assert_result_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(accept) && $stable(filter_idx)));

  // R3: an accepting filter is always enabled
  assert_winner_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && accept) |-> en_bits[filter_idx]);

  // R5: rejection reports index zero
  assert_reject_idx_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !accept) |-> (filter_idx == '0));

  // R7: the enable bitmap is frozen while the receiver is on
  assert_enable_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && rx_enable) |=> $stable(en_bits));

  // R8: no scan starts while the receiver is off
  assert_no_start_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_enable && !busy) |=> !busy);

endmodule

bind can_accept_filter_bank filt_bank_checker #(.NUM_FILTERS(NUM_FILTERS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .rx_enable  (rx_enable),
  .cfg_we     (cfg_we),
  .busy       (busy),
  .done       (done),
  .accept     (accept),
  .filter_idx (filter_idx),
  .en_bits    (en_bits)
);

// File: tb/can_accept_filter_bank_tb.sv
module can_accept_filter_bank_tb_top;

  localparam int N = 256;

  logic        clk;
  logic        rst_n;
  logic        rx_enable;
  logic        cfg_we;
  logic [1:0]  cfg_sel;
  logic [7:0]  cfg_addr;
  logic [47:0] cfg_wdata;
  logic        frame_valid;
  logic [47:0] frame_key;
  logic        done;
  logic        accept;
  logic [7:0]  filter_idx;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  localparam logic [47:0] K1     = 48'h1234_5678_9ABC;
  localparam logic [47:0] K10    = 48'hABCD_1357_2468;
  localparam logic [47:0] KMISS  = 48'h0000_0000_0001;
  localparam logic [47:0] K1FLIP = 48'h1234_5678_9ABD;
  localparam logic [47:0] ONES   = 48'hFFFF_FFFF_FFFF;

  can_accept_filter_bank dut_i (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .frame_valid(frame_valid), .frame_key(frame_key),
    .done(done), .accept(accept), .filter_idx(filter_idx)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog R1..: cycles=%0d expected below %0d", cycles, 150000);
        finish_run();
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] addr, input logic [47:0] data);
    cfg_we = 1'b1; cfg_sel = sel; cfg_addr = addr; cfg_wdata = data;
    @(posedge clk); @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_frame(input logic [47:0] key, output logic acc,
                           output logic [7:0] idx, output int lat);
    frame_valid = 1'b1; frame_key = key;
    @(posedge clk); @(negedge clk);
    frame_valid = 1'b0;
    lat = 0;
    while (lat < 400) begin
      @(posedge clk); lat++; @(negedge clk);
      if (done) break;
    end
    acc = accept; idx = filter_idx;
    @(posedge clk); @(negedge clk);
    check("R6", "done single pulse", done, 1'b0);
  endtask

  task automatic expect_frame(input string req, input logic [47:0] key,
                              input logic e_acc, input logic [7:0] e_idx, input int e_lat);
    logic acc; logic [7:0] idx; int lat;
    run_frame(key, acc, idx, lat);
    check(req, "accept", acc, e_acc);
    check(req, "filter_idx", idx, e_idx);
    check(req, "latency", lat, e_lat);
  endtask

  // R1: reset values, empty enable bitmap rejects everything
  task automatic t_reset();
    check("R1", "done after reset", done, 1'b0);
    check("R1", "accept after reset", accept, 1'b0);
    check("R1", "filter_idx after reset", filter_idx, 8'd0);
    rx_enable = 1'b1;
    expect_frame("R1", K1, 1'b0, 8'd0, N);
    rx_enable = 1'b0;
  endtask

  // R2/R5/R6: exact match, partial mask, miss, result holding
  task automatic t_basic();
    wr(2'd0, 8'd3, K1);                 wr(2'd1, 8'd3, ONES);
    wr(2'd0, 8'd10, 48'hABCD_0000_0000); wr(2'd1, 8'd10, 48'hFFFF_0000_0000);
    wr(2'd2, 8'd0, 8'h08);              wr(2'd2, 8'd1, 8'h04);
    wr(2'd3, 8'd0, 8'hFF);              // R3: sel 3 writes nothing
    rx_enable = 1'b1;
    expect_frame("R2", K1, 1'b1, 8'd3, 4);
    expect_frame("R2", K10, 1'b1, 8'd10, 11);
    expect_frame("R5", K1FLIP, 1'b0, 8'd0, N);
    expect_frame("R6", K1, 1'b1, 8'd3, 4);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R6", "accept held", accept, 1'b1);
    check("R6", "filter_idx held", filter_idx, 8'd3);
    rx_enable = 1'b0;
  endtask

  // R3/R4: byte/bit mapping of enables, lowest index wins
  task automatic t_priority();
    wr(2'd0, 8'd5, 48'd0);   wr(2'd1, 8'd5, 48'd0);    // catch-all, not enabled
    wr(2'd0, 8'd200, 48'd0); wr(2'd1, 8'd200, 48'd0);
    wr(2'd0, 8'd250, 48'd0); wr(2'd1, 8'd250, 48'd0);
    wr(2'd2, 8'd25, 8'h01);  wr(2'd2, 8'd31, 8'h04);
    rx_enable = 1'b1;
    expect_frame("R3", KMISS, 1'b1, 8'd200, 201);
    expect_frame("R4", K1, 1'b1, 8'd3, 4);
    expect_frame("R4", K10, 1'b1, 8'd10, 11);
    rx_enable = 1'b0;
  endtask

  // R7: writes while the receiver is on are dropped
  task automatic t_lock();
    rx_enable = 1'b1;
    wr(2'd2, 8'd0, 8'h28);
    wr(2'd1, 8'd3, 48'd0);
    wr(2'd0, 8'd10, K1FLIP);
    expect_frame("R7", KMISS, 1'b1, 8'd200, 201);
    expect_frame("R7", K10, 1'b1, 8'd10, 11);
    expect_frame("R7", K1FLIP, 1'b1, 8'd200, 201);
    rx_enable = 1'b0;
  endtask

  // R8: strobes ignored while off or while scanning
  task automatic t_ignore();
    int seen;
    logic res_acc; logic [7:0] res_idx;
    frame_valid = 1'b1; frame_key = K1;
    @(posedge clk); @(negedge clk);
    frame_valid = 1'b0;
    seen = 0;
    repeat (300) begin
      @(posedge clk); @(negedge clk);
      if (done) seen++;
    end
    check("R8", "done count while off", seen, 0);
    rx_enable = 1'b1;
    frame_valid = 1'b1; frame_key = KMISS;
    @(posedge clk); @(negedge clk);
    frame_valid = 1'b0;
    repeat (4) @(negedge clk);
    frame_valid = 1'b1; frame_key = K1;
    @(posedge clk); @(negedge clk);
    frame_valid = 1'b0;
    seen = 0; res_acc = 1'b0; res_idx = 8'd0;
    repeat (500) begin
      @(posedge clk); @(negedge clk);
      if (done) begin seen++; res_acc = accept; res_idx = filter_idx; end
    end
    check("R8", "done count with mid-scan strobe", seen, 1);
    check("R8", "accept of first frame", res_acc, 1'b1);
    check("R8", "filter_idx of first frame", res_idx, 8'd200);
    rx_enable = 1'b0;
  endtask

  // R3/R6: last filter alone, full-length accepting scan
  task automatic t_last();
    wr(2'd2, 8'd0, 8'h00); wr(2'd2, 8'd1, 8'h00);
    wr(2'd2, 8'd25, 8'h00); wr(2'd2, 8'd31, 8'h80);
    wr(2'd0, 8'd255, 48'd0); wr(2'd1, 8'd255, 48'd0);
    rx_enable = 1'b1;
    expect_frame("R3", K1, 1'b1, 8'd255, N);
    rx_enable = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; rx_enable = 1'b0; cfg_we = 1'b0; cfg_sel = 2'd0;
    cfg_addr = '0; cfg_wdata = '0; frame_valid = 1'b0; frame_key = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic();
    t_priority();
    t_lock();
    t_ignore();
    t_last();
    finish_run();
  end

endmodule